// File: doc/BRIEF.md
# Multi-Hart Machine Timer Unit

This block holds a free-running 64-bit real-time counter and one 64-bit compare register for each hart. Each hart has a level-sensitive timer interrupt output. That output is high whenever the hart's compare value is at or below the current time. The counter advances by one on every clock cycle in which the timebase tick-enable input is high.

Software reaches the counter and the compare registers over a simple register bus. A request carries an address, a size code, a write enable and write data. Read data comes back one cycle later. Either a full 64-bit access or two 32-bit halves can update any 64-bit register. A write to the counter at once re-evaluates every hart's interrupt against the new time. The hart count and the base offsets of the compare array and the time register are parameters.

Top module: `mtimer_unit`

## Requirements
- R1: After reset the time counter is zero, every compare register holds all ones, every interrupt output is low and the read data output is zero.
- R2: The time counter increments by one on each cycle in which tick_i is high. A software write to the counter in the same cycle takes priority over the increment.
- R3: With sz_i = 2'b10 (4 bytes), a write at TIME_BASE replaces time bits 31:0 and a write at TIME_BASE+4 replaces bits 63:32. With sz_i = 2'b11 (8 bytes), a write at TIME_BASE replaces all 64 bits. A 4-byte write uses wdata_i[31:0].
- R4: A 4-byte write to offset 0 or offset 4 of a compare slot replaces only the low or high 32 bits of that slot and keeps the other half unchanged. An 8-byte write at offset 0 replaces the whole slot.
- R5: An 8-byte write aimed at offset 4 of a compare slot, or at TIME_BASE+4, changes no state.
- R6: irq_o[i] is high exactly when compare register i is less than or equal to the time counter in an unsigned 64-bit comparison. It follows the registered values, so it changes in the cycle after the write or tick that causes the change.
- R7: A write to either half of the time counter, or to the whole counter, re-evaluates every hart's interrupt against the new time.
- R8: A read returns its data on rdata_o one cycle after the request. At offset 0 an 8-byte read returns the full register and a 4-byte read returns bits 31:0 zero-extended. At offset 4 a read returns bits 63:32 zero-extended. rdata_o holds its value between reads.
- R9: Reads at unmapped addresses, or at offsets within an 8-byte word other than 0 and 4, return zero. Writes at unmapped addresses have no effect.
- R10: Requests with a size code other than 2'b10 or 2'b11 are ignored. Writes change nothing, and reads return zero.
- R11: Compare slot i lives at CMP_BASE + 8*i, so the hart index is the slot offset shifted right by 3. A write to one slot leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick enable |
| req_i | input | 1 | Bus request valid |
| we_i | input | 1 | Write enable (0 = read) |
| sz_i | input | 2 | Access size code: 2'b10 = 4 bytes, 2'b11 = 8 bytes |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 64 | Write data, little-endian |
| rdata_o | output | 64 | Registered read data |
| irq_o | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The bench targets the following corner cases. The equality boundary between compare and time: an off-by-one comparator would miss the interrupt when the two are equal. A compare value with bit 63 set: a signed comparator would raise a false interrupt. Half-word writes: a design that cleared or shifted the other half would corrupt the slot. An 8-byte write at the high offset: a design that did not discard it would overwrite the register. A write to the high time half: a design that did not recompare after it would leave stale interrupts on some harts. A tick in the same cycle as a time write: a design with the wrong priority would read back one more than was written.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'b00,
    SZ_B2 = 2'b01,
    SZ_W4 = 2'b10,
    SZ_W8 = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic lo;
    logic hi;
  } half_we_t;

  // maps size and word offset onto per-half write enables; 8B at offset 4 drops
  function automatic half_we_t half_we(input logic en, input logic [1:0] sz,
                                       input logic [2:0] ofs);
    half_we_t h;
    h.lo = en && (ofs == 3'd0) && (sz == SZ_W4 || sz == SZ_W8);
    h.hi = en && (((ofs == 3'd0) && (sz == SZ_W8)) || ((ofs == 3'd4) && (sz == SZ_W4)));
    return h;
  endfunction
endpackage

// File: rtl/mtimer_reg64.sv
module mtimer_reg64 #(
  parameter logic [63:0] RST_VAL = 64'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_lo_i,
  input  logic        we_hi_i,
  input  logic [31:0] d_lo_i,
  input  logic [31:0] d_hi_i,
  input  logic        inc_i,
  output logic [63:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= RST_VAL;
    end else if (we_lo_i || we_hi_i) begin
      if (we_lo_i) q_o[31:0]  <= d_lo_i;
      if (we_hi_i) q_o[63:32] <= d_hi_i;
    end else if (inc_i) begin
      q_o <= q_o + 64'd1;
    end
  end

  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !we_lo_i && !we_hi_i) |=> (q_o == $past(q_o) + 64'd1));
  a_r2_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i && we_hi_i) |=> (q_o == {$past(d_hi_i), $past(d_lo_i)}));
  a_r4_keep_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lo_i && !we_hi_i) |=> (q_o[63:32] == $past(q_o[63:32])));
  a_r4_keep_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_hi_i && !we_lo_i) |=> (q_o[31:0] == $past(q_o[31:0])));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_lo_i && !we_hi_i && !inc_i) |=> $stable(q_o));
endmodule

// File: rtl/mtimer_rdmux.sv
module mtimer_rdmux
  import mtimer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        hit_i,
  input  logic [1:0]  sz_i,
  input  logic [2:0]  ofs_i,
  input  logic [63:0] word_i,
  output logic [63:0] rdata_o
);
  logic        sz_ok;
  logic [63:0] rd_val;

  assign sz_ok = (sz_i == SZ_W4) || (sz_i == SZ_W8);

  always_comb begin
    rd_val = 64'h0;
    if (hit_i && sz_ok) begin
      if (ofs_i == 3'd0)      rd_val = (sz_i == SZ_W8) ? word_i : {32'h0, word_i[31:0]};
      else if (ofs_i == 3'd4) rd_val = {32'h0, word_i[63:32]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 64'h0;
    else if (rd_i) rdata_o <= rd_val;
  end

  a_r9_misaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (ofs_i[1:0] != 2'b00)) |=> (rdata_o == 64'h0));
  a_r10_bad_size_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sz_i[1]) |=> (rdata_o == 64'h0));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  a_r8_high_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sz_i == SZ_W4) |=> (rdata_o[63:32] == 32'h0));
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import mtimer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMP_BASE  = 'h0200,
  parameter int unsigned TIME_BASE = 'h0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [1:0]           sz_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [63:0]          wdata_i,
  output logic [63:0]          rdata_o,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int unsigned      WA_W   = ADDR_W - 3;
  localparam logic [ADDR_W:0]  CMP_LO = (ADDR_W+1)'(CMP_BASE);
  localparam logic [ADDR_W:0]  CMP_HI = (ADDR_W+1)'(CMP_BASE + NUM_HARTS * 8);
  localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] TIM_A = ADDR_W'(TIME_BASE);

  logic            sz_ok, acc, in_cmp, in_time;
  logic [2:0]      ofs;
  logic [WA_W-1:0] slot;
  logic [31:0]     d_lo, d_hi;
  half_we_t        wr_h;
  logic [63:0]     time_q;
  logic [63:0]     cmp_q [NUM_HARTS];
  logic [NUM_HARTS-1:0] slot_hit;
  logic [63:0]     rd_word;
  logic            rd_hit;

  assign sz_ok   = (sz_i == SZ_W4) || (sz_i == SZ_W8);
  assign acc     = req_i && sz_ok;
  assign ofs     = addr_i[2:0];
  assign in_cmp  = ({1'b0, addr_i} >= CMP_LO) && ({1'b0, addr_i} < CMP_HI);
  assign in_time = (addr_i[ADDR_W-1:3] == TIM_A[ADDR_W-1:3]);
  assign slot    = addr_i[ADDR_W-1:3] - CMP_A[ADDR_W-1:3];
  assign wr_h    = half_we(acc && we_i, sz_i, ofs);
  assign d_lo    = wdata_i[31:0];
  assign d_hi    = (sz_i == SZ_W8) ? wdata_i[63:32] : wdata_i[31:0];

  mtimer_reg64 #(.RST_VAL(64'h0)) u_time (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_lo_i (wr_h.lo && in_time),
    .we_hi_i (wr_h.hi && in_time),
    .d_lo_i  (d_lo),
    .d_hi_i  (d_hi),
    .inc_i   (tick_i),
    .q_o     (time_q)
  );

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    assign slot_hit[i] = in_cmp && (slot == WA_W'(i));

    mtimer_reg64 #(.RST_VAL({64{1'b1}})) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_lo_i (wr_h.lo && slot_hit[i]),
      .we_hi_i (wr_h.hi && slot_hit[i]),
      .d_lo_i  (d_lo),
      .d_hi_i  (d_hi),
      .inc_i   (1'b0),
      .q_o     (cmp_q[i])
    );

    // unsigned compare on registered state re-evaluates after any time write
    assign irq_o[i] = (cmp_q[i] <= time_q);

    a_r11_other_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && !slot_hit[i]) |=> $stable(cmp_q[i]));
    a_r5_cmp_hi8_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && slot_hit[i] && sz_i == SZ_W8 && ofs == 3'd4) |=> $stable(cmp_q[i]));
  end

  always_comb begin
    rd_word = 64'h0;
    rd_hit  = 1'b0;
    if (in_time) begin
      rd_word = time_q;
      rd_hit  = 1'b1;
    end
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (slot_hit[i]) begin
        rd_word = cmp_q[i];
        rd_hit  = 1'b1;
      end
    end
  end

  mtimer_rdmux u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (req_i && !we_i),
    .hit_i   (rd_hit),
    .sz_i    (sz_i),
    .ofs_i   (ofs),
    .word_i  (rd_word),
    .rdata_o (rdata_o)
  );

  a_r5_time_hi8_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_time && sz_i == SZ_W8 && ofs == 3'd4 && !tick_i) |=> $stable(time_q));
  a_r10_bad_size_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sz_i[1] && !tick_i) |=> $stable(time_q));
  a_r3_low_write_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && in_time && sz_i == SZ_W4 && ofs == 3'd0) |=> (time_q[63:32] == $past(time_q[63:32])));
endmodule

// File: tb/mtimer_unit_bench.sv
module mtimer_unit_bench;
  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [63:0] wd;
    logic        chk;
    logic [63:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 29;
  // time at 0x0000, compare slots at 0x0200 + 8*i; sz 2'b10 = 4B, 2'b11 = 8B
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd3, 16'h0000, 64'h0, 1'b1, 64'h0, 4'd1},                                  // R1 time zero
    '{1'b0, 2'd3, 16'h0200, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd1},                // R1 cmp ones
    '{1'b1, 2'd3, 16'h0000, 64'h0000_0001_0000_0010, 1'b0, 64'h0, 4'd3},
    '{1'b0, 2'd3, 16'h0000, 64'h0, 1'b1, 64'h0000_0001_0000_0010, 4'd3},                // R3 full
    '{1'b1, 2'd2, 16'h0004, 64'hDEAD_BEEF_0000_0007, 1'b0, 64'h0, 4'd3},
    '{1'b0, 2'd3, 16'h0000, 64'h0, 1'b1, 64'h0000_0007_0000_0010, 4'd3},                // R3 high half
    '{1'b1, 2'd2, 16'h0000, 64'h1234_5678_AAAA_BBBB, 1'b0, 64'h0, 4'd3},
    '{1'b0, 2'd2, 16'h0000, 64'h0, 1'b1, 64'h0000_0000_AAAA_BBBB, 4'd8},                // R8 4B low
    '{1'b0, 2'd2, 16'h0004, 64'h0, 1'b1, 64'h0000_0000_0000_0007, 4'd8},                // R8 4B high
    '{1'b0, 2'd3, 16'h0004, 64'h0, 1'b1, 64'h0000_0000_0000_0007, 4'd8},                // R8 8B at +4
    '{1'b1, 2'd3, 16'h0004, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h0, 4'd5},
    '{1'b0, 2'd3, 16'h0000, 64'h0, 1'b1, 64'h0000_0007_AAAA_BBBB, 4'd5},                // R5 time drop
    '{1'b1, 2'd3, 16'h0208, 64'h1111_2222_3333_4444, 1'b0, 64'h0, 4'd4},
    '{1'b1, 2'd2, 16'h020C, 64'h0000_0000_5555_6666, 1'b0, 64'h0, 4'd4},
    '{1'b0, 2'd3, 16'h0208, 64'h0, 1'b1, 64'h5555_6666_3333_4444, 4'd4},                // R4 high half
    '{1'b1, 2'd2, 16'h0208, 64'h9999_9999_7777_8888, 1'b0, 64'h0, 4'd4},
    '{1'b0, 2'd2, 16'h020C, 64'h0, 1'b1, 64'h0000_0000_5555_6666, 4'd4},                // R4 keep high
    '{1'b0, 2'd2, 16'h0208, 64'h0, 1'b1, 64'h0000_0000_7777_8888, 4'd4},                // R4 low half
    '{1'b1, 2'd3, 16'h020C, 64'h0, 1'b0, 64'h0, 4'd5},
    '{1'b0, 2'd3, 16'h0208, 64'h0, 1'b1, 64'h5555_6666_7777_8888, 4'd5},                // R5 cmp drop
    '{1'b0, 2'd2, 16'h0209, 64'h0, 1'b1, 64'h0, 4'd9},                                  // R9 misaligned
    '{1'b1, 2'd3, 16'h0400, 64'h5, 1'b0, 64'h0, 4'd9},
    '{1'b0, 2'd3, 16'h0400, 64'h0, 1'b1, 64'h0, 4'd9},                                  // R9 unmapped
    '{1'b0, 2'd3, 16'h0220, 64'h0, 1'b1, 64'h0, 4'd9},                                  // R9 past array
    '{1'b1, 2'd1, 16'h0000, 64'h0, 1'b0, 64'h0, 4'd10},
    '{1'b0, 2'd3, 16'h0000, 64'h0, 1'b1, 64'h0000_0007_AAAA_BBBB, 4'd10},               // R10 write ignored
    '{1'b0, 2'd0, 16'h0000, 64'h0, 1'b1, 64'h0, 4'd10},                                 // R10 read zero
    '{1'b0, 2'd3, 16'h0218, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd11},               // R11 slot 3
    '{1'b0, 2'd3, 16'h0200, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd11}                // R11 slot 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sz = 2'd0;
  logic [15:0] addr = 16'h0;
  logic [63:0] wdata = 64'h0;
  logic [63:0] rdata;
  logic [3:0]  irq;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  mtimer_unit u_mtimer_unit (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .req_i (req), .we_i (we),
    .sz_i (sz), .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input int r);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] s, input logic [15:0] a,
                     input logic [63:0] d, input logic tk);
    @(negedge clk);
    req = 1'b1; we = w; sz = s; addr = a; wdata = d; tick = tk;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({60'h0, irq}, 64'h0, 1);   // R1 irq low
    check(rdata, 64'h0, 1);          // R1 rdata zero

    for (int k = 0; k < NV; k++) begin
      bus(TBL[k].we, TBL[k].sz, TBL[k].addr, TBL[k].wd, 1'b0);
      if (TBL[k].chk) check(rdata, TBL[k].exp, int'(TBL[k].rq));
    end
    check({60'h0, irq}, 64'h0, 6);   // R6 all compares in future

    bus(1'b1, 2'd3, 16'h0210, 64'h0000_0007_AAAA_BBBB, 1'b0);
    check({60'h0, irq}, 64'h4, 6);   // R6 equal raises
    bus(1'b1, 2'd3, 16'h0210, 64'h0000_0007_AAAA_BBBC, 1'b0);
    check({60'h0, irq}, 64'h0, 6);   // R6 future lowers

    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check({60'h0, irq}, 64'h4, 2);   // R2 tick reaches compare
    bus(1'b0, 2'd3, 16'h0000, 64'h0, 1'b0);
    check(rdata, 64'h0000_0007_AAAA_BBBC, 2);

    bus(1'b1, 2'd3, 16'h0200, 64'h8000_0000_0000_0000, 1'b0);
    check({60'h0, irq}, 64'h4, 6);   // R6 unsigned compare

    bus(1'b1, 2'd2, 16'h0004, 64'h0000_0000_FFFF_FFFF, 1'b0);
    check({60'h0, irq}, 64'h7, 7);   // R7 recompare after high write
    bus(1'b1, 2'd3, 16'h0000, 64'h0, 1'b0);
    check({60'h0, irq}, 64'h0, 7);   // R7 recompare after full write

    bus(1'b1, 2'd3, 16'h0000, 64'd100, 1'b1);
    bus(1'b0, 2'd3, 16'h0000, 64'h0, 1'b0);
    check(rdata, 64'd100, 2);        // R2 write beats tick

    @(negedge clk); tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    bus(1'b0, 2'd3, 16'h0000, 64'h0, 1'b0);
    check(rdata, 64'd105, 2);        // R2 count

    bus(1'b1, 2'd2, 16'h0218, 64'h0, 1'b0);
    check({60'h0, irq}, 64'h0, 11);  // R11 slot 3 low only
    bus(1'b1, 2'd2, 16'h021C, 64'h0, 1'b0);
    check({60'h0, irq}, 64'h8, 11);  // R11 slot 3 maps to irq bit 3

    finish_run();
  end
endmodule